// File: doc/BRIEF.md
# Gated Down Counter with Compare

This block is an 8-bit programmable down counter for a configurable digital fabric tile. Software programs it through a small register bus. A period write sets the reload value. A compare write sets the threshold for the primary output. A count read strobe captures the hidden count value into the compare register, and a compare read strobe returns that register. The count register cannot be written or read directly.

When enabled and gated, the counter steps down from the period value to zero and reloads on the clock after zero. A period of N therefore gives a cycle of N+1 clocks.

The block drives three registered outputs:
- a primary output from a selectable compare between the count and the compare register;
- an auxiliary terminal-count output;
- a one-clock interrupt pulse.

Two optional modes change reload and compare handling. A kill input can force a reload from the period register. A buffered-compare mode delays compare writes until the next reload, so the threshold never changes in mid-cycle.

Top module: `gated_down_counter`

## Requirements
- R1: After synchronous reset, and in any cycle that follows a cycle with `enable` low, `cmp_out`, `tc_out`, `irq` are 0; reset clears count, period and compare to 0.
- R2: With `enable` low, a `wr_period` strobe loads `wdata` into both the period register and the count register at the same edge.
- R3: With `enable` and `gate` high, a nonzero count decrements by one per clock. A zero count reloads from the period on the next clock, and `tc_out` is high in the cycle after each zero-count cycle.
- R4: With `enable` high and `gate` low (and no kill reload), the count holds its value and no terminal count is flagged.
- R5: A `wr_period` strobe while enabled changes only the period register. The count picks up the new value at the reload that follows terminal count.
- R6: While enabled with a period of 0, `tc_out` is 1 in every cycle after the first enabled cycle, whatever `gate` is.
- R7: With `kill_reload_mode` high and `enable` high, every clock with `kill` high loads the period into the count, overriding the gate. With `kill_reload_mode` low, `kill` has no effect.
- R8: A `rd_count` strobe makes `rdata` 0 on the next cycle. When `enable` is low or `gate` is low, it also copies the count into the compare register. A `rd_compare` strobe puts the compare register on `rdata` one cycle later; `rdata` is 0 otherwise.
- R9: `cmp_out` is registered and equals count < compare when `cmp_le_mode` is 0, or count <= compare when it is 1, evaluated on the previous cycle's values.
- R10: A `wr_compare` strobe writes the compare register directly when `cmp_buffer_mode` is low or `enable` is low.
- R11: With `cmp_buffer_mode` and `enable` high, a compare write is held in a shadow register. It moves into the compare register at the next count reload (terminal-count reload or kill reload).
- R12: `irq` is a registered one-cycle pulse. With `irq_on_cmp_mode` low it marks a terminal-count cycle. With it high it marks a 0-to-1 change of `cmp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable control bit |
| gate | input | 1 | Count gate data input |
| kill | input | 1 | Kill input |
| kill_reload_mode | input | 1 | 1: kill forces a period reload |
| cmp_le_mode | input | 1 | 0: less-than compare, 1: less-or-equal compare |
| irq_on_cmp_mode | input | 1 | 0: interrupt on terminal count, 1: on compare rising edge |
| cmp_buffer_mode | input | 1 | 1: compare writes while enabled wait for reload |
| wr_period | input | 1 | Period register write strobe |
| wr_compare | input | 1 | Compare register write strobe |
| rd_count | input | 1 | Count read strobe (snapshot into compare) |
| rd_compare | input | 1 | Compare register read strobe |
| wdata | input | WIDTH | Bus write data |
| rdata | output | WIDTH | Registered bus read data |
| cmp_out | output | 1 | Primary compare output |
| tc_out | output | 1 | Auxiliary terminal-count output |
| irq | output | 1 | Interrupt pulse |

## Verification
The main function is swept over every period from 0 to 7 and every compare value from 0 to 8, under both compare types and both interrupt sources, with the gate held high for two full count cycles. An arithmetic reference model predicts each output every cycle.
- The period sweep separates the zero-period constant-high case from normal reload spacing.
- Compare values at and beyond the period separate less-than from less-or-equal, including the always-true and never-true ends.
- Directed sequences check behaviour that a free-running sweep cannot separate: gate-low holding, a mid-count period change, kill reload against kill ignored, count snapshots in the gated and ungated states, and buffered against direct compare commits.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
  typedef enum logic {
    CMP_LT = 1'b0,
    CMP_LE = 1'b1
  } cmp_kind_e;

  typedef enum logic {
    IRQ_SRC_TC  = 1'b0,
    IRQ_SRC_CMP = 1'b1
  } irq_src_e;
endpackage

// File: rtl/gdc_count_core.sv
module gdc_count_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             gate,
  input  logic             kill,
  input  logic             kill_reload_mode,
  input  logic             wr_period,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] count_q,
  output logic [WIDTH-1:0] period_q,
  output logic             tc_now,
  output logic             reload
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic kill_hit;

  assign kill_hit = enable && kill_reload_mode && kill;
  assign tc_now   = enable && gate && (count_q == ZERO);
  assign reload   = kill_hit || tc_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= ZERO;
    end else if (wr_period) begin
      period_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= ZERO;
    end else if (!enable) begin
      if (wr_period) count_q <= wdata;
    end else if (kill_hit) begin
      count_q <= period_q;
    end else if (gate) begin
      if (count_q == ZERO) count_q <= period_q;
      else                 count_q <= count_q - ONE;
    end
  end
endmodule

// File: rtl/gdc_compare_reg.sv
module gdc_compare_reg #(
  parameter int WIDTH        = 8,
  parameter bit HAS_BUFFER   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             gate,
  input  logic             buffered,
  input  logic             wr_compare,
  input  logic             rd_count,
  input  logic             reload,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] count_q,
  output logic [WIDTH-1:0] compare_q
);
  logic snap;
  assign snap = rd_count && (!enable || !gate);

  generate
    if (HAS_BUFFER) begin : g_buf
      logic [WIDTH-1:0] shadow_q;
      logic             pending_q;
      logic             hold_write;

      assign hold_write = buffered && enable;

      always_ff @(posedge clk) begin
        if (rst) begin
          shadow_q  <= '0;
          pending_q <= 1'b0;
          compare_q <= '0;
        end else begin
          if (reload && pending_q) begin
            compare_q <= shadow_q;
            pending_q <= 1'b0;
          end
          if (wr_compare) begin
            if (hold_write) begin
              shadow_q  <= wdata;
              pending_q <= 1'b1;
            end else begin
              compare_q <= wdata;
            end
          end else if (snap) begin
            compare_q <= count_q;
          end
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst)             compare_q <= '0;
        else if (wr_compare) compare_q <= wdata;
        else if (snap)       compare_q <= count_q;
      end
    end
  endgenerate
endmodule

// File: rtl/gdc_out_stage.sv
module gdc_out_stage
  import gdc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  cmp_kind_e        cmp_kind,
  input  irq_src_e         irq_src,
  input  logic             tc_now,
  input  logic [WIDTH-1:0] count_q,
  input  logic [WIDTH-1:0] compare_q,
  input  logic [WIDTH-1:0] period_q,
  output logic             cmp_out,
  output logic             tc_out,
  output logic             irq
);
  logic cmp_now;
  logic irq_now;

  always_comb begin
    if (cmp_kind == CMP_LE) cmp_now = (count_q <= compare_q);
    else                    cmp_now = (count_q <  compare_q);
  end

  always_comb begin
    if (irq_src == IRQ_SRC_CMP) irq_now = cmp_now && !cmp_out;
    else                        irq_now = tc_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_out <= 1'b0;
      tc_out  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      cmp_out <= enable && cmp_now;
      tc_out  <= enable && ((period_q == '0) || tc_now);
      irq     <= enable && irq_now;
    end
  end
endmodule

// File: rtl/gated_down_counter.sv
module gated_down_counter
  import gdc_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit HAS_BUFFER = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             gate,
  input  logic             kill,
  input  logic             kill_reload_mode,
  input  logic             cmp_le_mode,
  input  logic             irq_on_cmp_mode,
  input  logic             cmp_buffer_mode,
  input  logic             wr_period,
  input  logic             wr_compare,
  input  logic             rd_count,
  input  logic             rd_compare,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             cmp_out,
  output logic             tc_out,
  output logic             irq
);
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] period_q;
  logic [WIDTH-1:0] compare_q;
  logic             tc_now;
  logic             reload;

  gdc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk              (clk),
    .rst              (rst),
    .enable           (enable),
    .gate             (gate),
    .kill             (kill),
    .kill_reload_mode (kill_reload_mode),
    .wr_period        (wr_period),
    .wdata            (wdata),
    .count_q          (count_q),
    .period_q         (period_q),
    .tc_now           (tc_now),
    .reload           (reload)
  );

  gdc_compare_reg #(.WIDTH(WIDTH), .HAS_BUFFER(HAS_BUFFER)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .gate       (gate),
    .buffered   (cmp_buffer_mode),
    .wr_compare (wr_compare),
    .rd_count   (rd_count),
    .reload     (reload),
    .wdata      (wdata),
    .count_q    (count_q),
    .compare_q  (compare_q)
  );

  gdc_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .cmp_kind  (cmp_kind_e'(cmp_le_mode)),
    .irq_src   (irq_src_e'(irq_on_cmp_mode)),
    .tc_now    (tc_now),
    .count_q   (count_q),
    .compare_q (compare_q),
    .period_q  (period_q),
    .cmp_out   (cmp_out),
    .tc_out    (tc_out),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst)                          rdata <= '0;
    else if (rd_compare && !rd_count) rdata <= compare_q;
    else                              rdata <= '0;
  end
endmodule

// File: rtl/gdc_checker.sv
module gdc_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             gate,
  input logic             kill,
  input logic             kill_reload_mode,
  input logic             irq_on_cmp_mode,
  input logic             wr_period,
  input logic             rd_count,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] count_q,
  input logic [WIDTH-1:0] period_q,
  input logic             cmp_out,
  input logic             tc_out,
  input logic             irq
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!cmp_out && !tc_out && !irq)); // R1

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (enable && gate && !(kill_reload_mode && kill) && count_q != '0)
      |=> count_q == WIDTH'($past(count_q) - WIDTH'(1))); // R3

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (enable && !gate && !(kill_reload_mode && kill)) |=> $stable(count_q)); // R4

  AST_ZERO_PERIOD_TC: assert property (@(posedge clk) disable iff (rst)
    (enable && period_q == '0) |=> tc_out); // R6

  AST_KILL_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (enable && kill_reload_mode && kill) |=> count_q == $past(period_q)); // R7

  AST_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_count |=> rdata == '0); // R8

  AST_IRQ_CMP_EDGE: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(irq_on_cmp_mode) && !$past(rst)) |-> (cmp_out && !$past(cmp_out))); // R12

  AST_DISABLED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!enable && wr_period) |=> count_q == period_q); // R2
endmodule

bind gated_down_counter gdc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .enable           (enable),
  .gate             (gate),
  .kill             (kill),
  .kill_reload_mode (kill_reload_mode),
  .irq_on_cmp_mode  (irq_on_cmp_mode),
  .wr_period        (wr_period),
  .rd_count         (rd_count),
  .rdata            (rdata),
  .count_q          (count_q),
  .period_q         (period_q),
  .cmp_out          (cmp_out),
  .tc_out           (tc_out),
  .irq              (irq)
);

// File: tb/gated_down_counter_test.sv
module gated_down_counter_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, gate = 0, kill = 0, kmode = 0, le = 0, irqm = 0, bufm = 0;
  logic wr_p = 0, wr_c = 0, rd_n = 0, rd_c = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic cmp_out, tc_out, irq;

  int checks = 0;
  int fails = 0;
  bit model_on = 0;
  string cur = "R1";

  always #5 clk = ~clk;

  gated_down_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .enable(en), .gate(gate), .kill(kill),
    .kill_reload_mode(kmode), .cmp_le_mode(le), .irq_on_cmp_mode(irqm),
    .cmp_buffer_mode(bufm), .wr_period(wr_p), .wr_compare(wr_c),
    .rd_count(rd_n), .rd_compare(rd_c), .wdata(wdata), .rdata(rdata),
    .cmp_out(cmp_out), .tc_out(tc_out), .irq(irq)
  );

  // Reference model, built from the requirement text
  logic [W-1:0] m_cnt, m_per, m_cmp, m_sh, m_rd;
  logic m_pend, m_co, m_tc, m_irq;

  always @(posedge clk) begin
    logic rl, tcz, cn;
    if (rst) begin
      m_cnt <= 0; m_per <= 0; m_cmp <= 0; m_sh <= 0; m_pend <= 0;
      m_co <= 0; m_tc <= 0; m_irq <= 0; m_rd <= 0;
    end else begin
      tcz = en && gate && (m_cnt == 0);
      rl  = (en && kmode && kill) || tcz;
      cn  = le ? (m_cnt <= m_cmp) : (m_cnt < m_cmp);
      if (wr_p) m_per <= wdata;
      if (!en) begin
        if (wr_p) m_cnt <= wdata;
      end else if (kmode && kill) m_cnt <= m_per;
      else if (gate) m_cnt <= (m_cnt == 0) ? m_per : m_cnt - 1;
      if (rl && m_pend) begin m_cmp <= m_sh; m_pend <= 0; end
      if (wr_c) begin
        if (bufm && en) begin m_sh <= wdata; m_pend <= 1; end
        else m_cmp <= wdata;
      end else if (rd_n && (!en || !gate)) m_cmp <= m_cnt;
      m_co  <= en && cn;
      m_tc  <= en && ((m_per == 0) || tcz);
      m_irq <= en && (irqm ? (cn && !m_co) : tcz);
      m_rd  <= rd_n ? 0 : (rd_c ? m_cmp : 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (phase %s)", tag, act, exp, cur);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(tc_out == m_tc, "R3 tc_out", tc_out, m_tc);
      chk(cmp_out == m_co, "R9 cmp_out", cmp_out, m_co);
      chk(irq == m_irq, "R12 irq", irq, m_irq);
      chk(rdata == m_rd, "R8 rdata", rdata, m_rd);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_period(input logic [W-1:0] v);
    wr_p = 1; wdata = v; tick(); wr_p = 0;
  endtask

  task automatic put_cmp(input logic [W-1:0] v);
    wr_c = 1; wdata = v; tick(); wr_c = 0;
  endtask

  task automatic snap_count();
    rd_n = 1; tick(); rd_n = 0;
    chk(rdata == 0, "R8 count read value", rdata, 0);
  endtask

  task automatic read_cmp_expect(input logic [W-1:0] exp, input string tag);
    rd_c = 1; tick(); rd_c = 0;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic quiesce();
    en = 0; gate = 0; kill = 0; kmode = 0; bufm = 0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick();
    chk(!cmp_out && !tc_out && !irq && rdata == 0, "R1 reset outputs",
        {cmp_out, tc_out, irq}, 0);
    model_on = 1;
    read_cmp_expect(8'h00, "R1 reset compare");

    cur = "R2";
    put_period(8'd9); snap_count();
    read_cmp_expect(8'd9, "R2 disabled period load");

    cur = "R10";
    put_cmp(8'h33); read_cmp_expect(8'h33, "R10 direct compare write");

    cur = "R4";
    put_period(8'd6); en = 1; gate = 1; tick(2); gate = 0; tick(5);
    chk(!tc_out, "R4 no tc while gated off", tc_out, 0);
    snap_count(); read_cmp_expect(8'd4, "R4 count held");

    cur = "R5";
    quiesce(); put_period(8'd3); en = 1; gate = 1; tick(); gate = 0;
    put_period(8'd7); snap_count(); read_cmp_expect(8'd2, "R5 count unchanged by period write");
    gate = 1; tick(3); gate = 0; snap_count();
    read_cmp_expect(8'd7, "R5 new period after reload");

    cur = "R6";
    quiesce(); put_period(8'd0); en = 1; gate = 0; tick(2);
    chk(tc_out, "R6 zero period tc high gate low", tc_out, 1);
    gate = 1; tick(3);
    chk(tc_out, "R6 zero period tc high gate high", tc_out, 1);

    cur = "R7";
    quiesce(); put_period(8'd5); en = 1; gate = 1; tick(3);
    kmode = 1; kill = 1; tick(3); kill = 0; gate = 0;
    snap_count(); read_cmp_expect(8'd5, "R7 kill reload");
    kmode = 0; kill = 1; gate = 1; tick(2); gate = 0; kill = 0;
    snap_count(); read_cmp_expect(8'd3, "R7 kill ignored when mode off");

    cur = "R8";
    quiesce(); put_period(8'd20); put_cmp(8'h55); en = 1; gate = 1;
    snap_count(); read_cmp_expect(8'h55, "R8 no snapshot while counting");

    cur = "R11";
    quiesce(); put_period(8'd4); put_cmp(8'd1);
    bufm = 1; en = 1; gate = 1; tick(); put_cmp(8'd3);
    read_cmp_expect(8'd1, "R11 held before reload");
    tick(6); read_cmp_expect(8'd3, "R11 committed at reload");
    quiesce(); put_cmp(8'd2); read_cmp_expect(8'd2, "R10 direct when disabled in buffer mode");

    // Sweep: period 0..7, compare 0..8, both compare types, both irq sources
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 9; c++) begin
        for (int m = 0; m < 4; m++) begin
          cur = "R9 sweep";
          quiesce();
          le = m[0]; irqm = m[1];
          put_period(W'(p)); put_cmp(W'(c));
          en = 1; gate = 1;
          tick(2 * (p + 1) + 3);
        end
      end
    end
    quiesce();
    tick(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule